// File: doc/BRIEF.md
# Paged Microcode Register Window

This block decodes 32-bit word accesses from a host bus into the programming space of a small vector processor. One byte-addressed space reaches three kinds of storage. Twelve control words sit at the bottom. A 128-entry general register file follows, then a 2048-word microcode store that is seen through a 512-word window. One of the control words is a page selector. It picks which quarter of the microcode store the window exposes, so a host can load and inspect the whole program through a small aperture.

The host presents a request in a single cycle. The request carries a valid strobe, a write flag, a byte address and write data. Writes take effect at that clock edge. Read data and a read-valid strobe appear one cycle later. The execution engine is a separate block. This block only hands it a one-cycle start pulse when the host writes the start bit of the control word. Any access that falls between the mapped regions leaves storage untouched and raises a one-cycle error flag.

Top module: `paged_regwin`

## Requirements
- R1: After reset every mapped location reads as zero, including the page selector and all 2048 microcode words. `rd_data_o` is zero in every cycle in which `rd_valid_o` is low.
- R2: Word indices 1 to 11 (byte address = 4 × index) are plain 32-bit read/write control words. Index 0 is the command word and always reads as zero.
- R3: A write to word index 0 with data bit 0 set drives `start_o` high for exactly the one cycle after the request. A write to index 0 with bit 0 clear gives no pulse. Neither write changes the value read from index 0.
- R4: Word indices 0x100 to 0x17F read and write general registers 0 to 127, in order.
- R5: Word indices 0x200 to 0x3FF reach microcode word 512 × page + (index − 0x200). The page is taken from the page selector at control word index 4.
- R6: Only bits 1:0 of the page selector form the microcode page. Its other bits are stored and read back, but they do not change which word the window reaches.
- R7: An access to an unmapped word index (12 to 0xFF, or 0x180 to 0x1FF) raises `err_o` for the one cycle after the request. A read there returns zero, and a write there changes no mapped location.
- R8: Each read request is answered one cycle later with `rd_valid_o` high for one cycle. Write requests and idle cycles produce no `rd_valid_o`.
- R9: Address bits 1:0 take no part in decoding, so all four byte addresses of a word reach the same location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid with `rd_valid_o` |
| rd_valid_o | output | 1 | Read response strobe |
| err_o | output | 1 | Unmapped access flag |
| start_o | output | 1 | Start pulse to the execution engine |

## Verification
The hardest case to reach is a microcode word that can only be seen while a different page is selected. A word written through the window is visible only under its own page, so any aliasing between pages stays hidden unless every quarter holds distinct data. The stimulus therefore fills all four pages through the same window with values that depend on the absolute word number. It then reselects each page with junk in the upper selector bits and reads every word back. Unmapped writes are proven harmless by sweeping every hole and then rereading all control and general registers.

// File: rtl/paged_regwin_pkg.sv
package paged_regwin_pkg;

    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_GPR  = 2'd1,
        RGN_CODE = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        err;
        logic        start;
    } resp_t;

    localparam int START_BIT = 0;

endpackage

// File: rtl/paged_regwin_decode.sv
module paged_regwin_decode
    import paged_regwin_pkg::*;
#(
    parameter int WIDX_W     = 10,
    parameter int CTRL_COUNT = 12,
    parameter int GPR_BASE   = 256,
    parameter int GPR_COUNT  = 128,
    parameter int CODE_BASE  = 512,
    parameter int PAGE_WORDS = 512
) (
    input  logic [WIDX_W-1:0] widx,
    output region_e           region
);
    localparam int CW = WIDX_W + 1;
    localparam logic [CW-1:0] CTRL_HI = CW'(CTRL_COUNT);
    localparam logic [CW-1:0] GPR_LO  = CW'(GPR_BASE);
    localparam logic [CW-1:0] GPR_HI  = CW'(GPR_BASE + GPR_COUNT);
    localparam logic [CW-1:0] CODE_LO = CW'(CODE_BASE);
    localparam logic [CW-1:0] CODE_HI = CW'(CODE_BASE + PAGE_WORDS);

    logic [CW-1:0] w;

    always_comb begin
        w = {1'b0, widx};
        if (w < CTRL_HI)
            region = RGN_CTRL;
        else if (w >= GPR_LO && w < GPR_HI)
            region = RGN_GPR;
        else if (w >= CODE_LO && w < CODE_HI)
            region = RGN_CODE;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/paged_regwin_ctrl.sv
module paged_regwin_ctrl #(
    parameter int NREG     = 12,
    parameter int DW       = 32,
    parameter int PAGE_REG = 4,
    parameter int PG_W     = 2,
    localparam int IW      = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [PG_W-1:0] page_o
);
    localparam logic [IW-1:0] LAST = IW'(NREG - 1);

    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    // Index 0 is the command word: never stored, reads zero.
    always_comb begin
        for (int i = 0; i < NREG; i++)
            regs_d[i] = regs_q[i];
        if (we && idx != '0 && idx <= LAST)
            regs_d[idx] = wdata;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= regs_d[i];
        end
    end

    assign rdata  = (idx <= LAST) ? regs_q[idx] : '0;
    assign page_o = regs_q[PAGE_REG][PG_W-1:0];
endmodule

// File: rtl/paged_regwin_store.sv
module paged_regwin_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/paged_regwin.sv
module paged_regwin
    import paged_regwin_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int CTRL_COUNT = 12,
    parameter int PAGE_REG   = 4,
    parameter int GPR_BASE   = 256,
    parameter int GPR_COUNT  = 128,
    parameter int CODE_BASE  = 512,
    parameter int PAGE_WORDS = 512,
    parameter int PAGES      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data_o,
    output logic              rd_valid_o,
    output logic              err_o,
    output logic              start_o
);
    localparam int DW      = 32;
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int CTRL_IW = $clog2(CTRL_COUNT);
    localparam int GPR_IW  = $clog2(GPR_COUNT);
    localparam int PAGE_IW = $clog2(PAGE_WORDS);
    localparam int PG_W    = $clog2(PAGES);
    localparam int CODE_DEPTH = PAGES * PAGE_WORDS;
    localparam int CODE_AW    = $clog2(CODE_DEPTH);
    localparam logic [WIDX_W-1:0] GPR_BASE_W  = WIDX_W'(GPR_BASE);
    localparam logic [WIDX_W-1:0] CODE_BASE_W = WIDX_W'(CODE_BASE);

    logic [WIDX_W-1:0] widx;
    logic              lane_bits_unused;
    region_e           region;

    assign widx             = bus_addr[ADDR_W-1:2];
    assign lane_bits_unused = ^bus_addr[1:0];

    paged_regwin_decode #(
        .WIDX_W     (WIDX_W),
        .CTRL_COUNT (CTRL_COUNT),
        .GPR_BASE   (GPR_BASE),
        .GPR_COUNT  (GPR_COUNT),
        .CODE_BASE  (CODE_BASE),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_decode (
        .widx   (widx),
        .region (region)
    );

    logic [CTRL_IW-1:0] ctrl_idx;
    logic [GPR_IW-1:0]  gpr_idx;
    logic [PAGE_IW-1:0] code_off;
    logic [PG_W-1:0]    page;
    logic [CODE_AW-1:0] code_addr;
    logic               wr_req;
    logic               ctrl_we, gpr_we, code_we;
    logic [DW-1:0]      ctrl_rdata, gpr_rdata, code_rdata;

    assign ctrl_idx  = CTRL_IW'(widx);
    assign gpr_idx   = GPR_IW'(widx - GPR_BASE_W);
    assign code_off  = PAGE_IW'(widx - CODE_BASE_W);
    assign code_addr = {page, code_off};

    assign wr_req  = bus_valid && bus_write;
    assign ctrl_we = wr_req && region == RGN_CTRL;
    assign gpr_we  = wr_req && region == RGN_GPR;
    assign code_we = wr_req && region == RGN_CODE;

    paged_regwin_ctrl #(
        .NREG     (CTRL_COUNT),
        .DW       (DW),
        .PAGE_REG (PAGE_REG),
        .PG_W     (PG_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .idx    (ctrl_idx),
        .wdata  (bus_wdata),
        .rdata  (ctrl_rdata),
        .page_o (page)
    );

    paged_regwin_store #(
        .DEPTH (GPR_COUNT),
        .DW    (DW)
    ) u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gpr_we),
        .addr  (gpr_idx),
        .wdata (bus_wdata),
        .rdata (gpr_rdata)
    );

    paged_regwin_store #(
        .DEPTH (CODE_DEPTH),
        .DW    (DW)
    ) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (code_we),
        .addr  (code_addr),
        .wdata (bus_wdata),
        .rdata (code_rdata)
    );

    resp_t resp_d, resp_q;

    always_comb begin
        resp_d        = '0;
        resp_d.rvalid = bus_valid && !bus_write;
        resp_d.err    = bus_valid && region == RGN_NONE;
        resp_d.start  = ctrl_we && ctrl_idx == '0 && bus_wdata[START_BIT];
        if (resp_d.rvalid) begin
            unique case (region)
                RGN_CTRL: resp_d.rdata = ctrl_rdata;
                RGN_GPR:  resp_d.rdata = gpr_rdata;
                RGN_CODE: resp_d.rdata = code_rdata;
                default:  resp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            resp_q <= '0;
        else
            resp_q <= resp_d;
    end

    assign rd_data_o  = resp_q.rdata;
    assign rd_valid_o = resp_q.rvalid;
    assign err_o      = resp_q.err;
    assign start_o    = resp_q.start;
endmodule

// File: rtl/paged_regwin_chk.sv
module paged_regwin_chk #(
    parameter int WIDX_W     = 10,
    parameter int CTRL_COUNT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [WIDX_W-1:0] widx,
    input logic              start_bit,
    input logic [31:0]       rd_data_o,
    input logic              rd_valid_o,
    input logic              err_o,
    input logic              start_o
);
    // R8
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write |=> rd_valid_o);

    // R8
    rvalid_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rd_valid_o);

    // R1
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> rd_data_o == 32'd0);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(bus_valid && bus_write && widx == '0 && start_bit));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(bus_valid && widx >= WIDX_W'(CTRL_COUNT)));

    // R7
    err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && rd_valid_o |-> rd_data_o == 32'd0);
endmodule

bind paged_regwin paged_regwin_chk #(
    .WIDX_W     (ADDR_W - 2),
    .CTRL_COUNT (CTRL_COUNT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .widx       (bus_addr[ADDR_W-1:2]),
    .start_bit  (bus_wdata[0]),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .err_o      (err_o),
    .start_o    (start_o)
);

// File: tb/paged_regwin_tb.sv
module paged_regwin_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data_o;
    logic        rd_valid_o, err_o, start_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    paged_regwin u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .err_o      (err_o),
        .start_o    (start_o)
    );

    function automatic logic [31:0] pat(int k);
        return 32'(k) * 32'h9E37_79B1 + 32'h0F0F_1234;
    endfunction

    task automatic check(string tag, logic [34:0] act, logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write: drive at negedge, flags observed at the next negedge.
    task automatic wr(int widx, logic [31:0] d, bit exp_err, bit exp_start, string tag);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 12'(widx * 4); bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        check(tag, {32'd0, rd_valid_o, err_o, start_o}, {32'd0, 1'b0, exp_err, exp_start});
    endtask

    task automatic rd_b(logic [11:0] baddr, logic [31:0] exp, bit exp_err, string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = baddr;
        @(negedge clk);
        bus_valid = 1'b0;
        check(tag, {rd_data_o, rd_valid_o, err_o, start_o}, {exp, 1'b1, exp_err, 1'b0});
    endtask

    task automatic rd(int widx, logic [31:0] exp, bit exp_err, string tag);
        rd_b(12'(widx * 4), exp, exp_err, tag);
    endtask

    task automatic idle(string tag);
        bus_valid = 1'b0;
        @(negedge clk);
        check(tag, {rd_data_o, rd_valid_o, err_o, start_o}, 35'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        do_reset();

        // R1: everything reads zero out of reset
        idle("R1 idle outputs");
        for (int i = 0; i < 12; i++) rd(i, 32'd0, 0, "R1 ctrl reset");
        for (int i = 0; i < 128; i++) rd(256 + i, 32'd0, 0, "R1 gpr reset");
        for (int i = 0; i < 512; i++) rd(512 + i, 32'd0, 0, "R1 code reset");

        // R2: control words 1..11 hold data, index 0 reads zero
        for (int i = 1; i < 12; i++) wr(i, pat(1000 + i), 0, 0, "R2 ctrl write");
        wr(0, 32'hFFFF_FFFE, 0, 0, "R3 no start without bit0");
        idle("R3 no pulse");
        for (int i = 1; i < 12; i++) rd(i, pat(1000 + i), 0, "R2 ctrl readback");
        rd(0, 32'd0, 0, "R2 command word reads zero");

        // R3: start pulse lasts one cycle, command word stays zero
        wr(0, 32'h0000_0001, 0, 1, "R3 start pulse");
        idle("R3 pulse one cycle");
        wr(0, 32'hFFFF_FFFF, 0, 1, "R3 start pulse all ones");
        wr(0, 32'h0000_0001, 0, 1, "R3 back-to-back start");
        idle("R3 pulse ends");
        rd(0, 32'd0, 0, "R3 command word unchanged");

        // R4: general registers
        for (int i = 0; i < 128; i++) wr(256 + i, pat(2000 + i), 0, 0, "R4 gpr write");
        for (int i = 0; i < 128; i++) rd(256 + i, pat(2000 + i), 0, "R4 gpr readback");

        // R5: fill all four pages through the window
        for (int p = 0; p < 4; p++) begin
            wr(4, 32'(p), 0, 0, "R5 page select");
            for (int i = 0; i < 512; i++)
                wr(512 + i, pat(3000 + p * 512 + i), 0, 0, "R5 code write");
        end
        // R6: upper selector bits set, only bits 1:0 pick the page
        for (int p = 3; p >= 0; p--) begin
            logic [31:0] sel;
            sel = 32'hABCD_5670 | 32'(p);
            wr(4, sel, 0, 0, "R6 page select junk");
            rd(4, sel, 0, "R6 selector reads back in full");
            for (int i = 0; i < 512; i++)
                rd(512 + i, pat(3000 + p * 512 + i), 0, "R5 R6 code readback");
        end

        // R7: every hole flags, reads zero, writes dropped
        for (int w = 12; w < 256; w++) begin
            wr(w, 32'hDEAD_0000 | 32'(w), 1, 0, "R7 hole write err");
            rd(w, 32'd0, 1, "R7 hole read zero");
        end
        for (int w = 384; w < 512; w++) begin
            wr(w, 32'hBEEF_0000 | 32'(w), 1, 0, "R7 hole write err");
            rd(w, 32'd0, 1, "R7 hole read zero");
        end
        idle("R7 err one cycle");
        for (int i = 1; i < 12; i++)
            rd(i, (i == 4) ? 32'hABCD_5670 : pat(1000 + i), 0, "R7 ctrl untouched");
        for (int i = 0; i < 128; i++) rd(256 + i, pat(2000 + i), 0, "R7 gpr untouched");
        for (int i = 0; i < 512; i++) rd(512 + i, pat(3000 + i), 0, "R7 code untouched");

        // R9: byte lanes ignored
        for (int b = 1; b < 4; b++)
            rd_b(12'((256 + 5) * 4 + b), pat(2005), 0, "R9 gpr byte lane");
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = 12'((512 + 7) * 4 + 3); bus_wdata = 32'h1234_5678;
        @(negedge clk);
        bus_valid = 1'b0;
        rd(512 + 7, 32'h1234_5678, 0, "R9 code write byte lane");
        rd_b(12'h003, 32'd0, 0, "R9 command lane");

        // R8: writes give no read strobe, reads give one each
        wr(300, pat(9), 0, 0, "R8 no rvalid on write");
        rd(300, pat(9), 0, "R8 rvalid on read");
        idle("R8 no rvalid idle");

        // R1: second reset clears all pages and registers
        do_reset();
        rd(4, 32'd0, 0, "R1 selector cleared");
        for (int i = 1; i < 12; i++) rd(i, 32'd0, 0, "R1 ctrl cleared");
        for (int i = 0; i < 128; i++) rd(256 + i, 32'd0, 0, "R1 gpr cleared");
        for (int p = 0; p < 4; p++) begin
            wr(4, 32'(p), 0, 0, "R1 page select");
            for (int i = 0; i < 512; i += 37) rd(512 + i, 32'd0, 0, "R1 code cleared");
            rd(1023, 32'd0, 0, "R1 code last word cleared");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule